// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This block decides when the measurement core of a chip may run. It keeps the core disabled while the supply-good indication is low. Once the supply is good, it waits a fixed hold time and then enables the core. It then waits a second fixed settling time, and at the end of that time it declares the chip ready. The same sequence starts over from the hold step after a hardware reset on the external pin or after a one-cycle software reset strobe.

When the chip becomes ready, the block sets the reset-done flag in bit 0 of an interrupt status register and drives the active-low interrupt pin low. The reset-done flag cannot be masked. Other interrupt sources set the higher status bits and can pull the pin low only through their enable bits. The host clears a status bit by writing a one to it.

Delay lengths and the pin-qualification length are parameters, so a simulation can use short counts while silicon uses the real millisecond values.

Top module: `pwrup_seq`

## Requirements
- R1: While `supply_ok` is low, `core_en` is 0, `irq_stat` is all zeros and `irq_n` is 1. After a fall of `supply_ok`, `core_en` is first seen low 3 cycles later (two synchronizer flops plus the state register).
- R2: After `supply_ok` rises, `core_en` first reads 1 exactly 3 + HOLD_CYC cycles later.
- R3: Exactly BOOT_CYC cycles after `core_en` rises, `irq_stat` bit 0 (reset-done) becomes 1 and `irq_n` goes low.
- R4: `irq_en` bit 0 has no effect. While `irq_stat` bit 0 is 1, `irq_n` is 0 whatever the enables hold.
- R5: A low pulse on `rst_pin_n` that lasts QUAL_CYC-1 cycles or fewer is ignored. A low pulse of QUAL_CYC cycles or more drops `core_en` QUAL_CYC + 3 cycles after the pulse starts and clears `irq_stat`.
- R6: While `rst_pin_n` stays low, the sequence is held at the start of the hold step. For a low pulse of N cycles, `core_en` returns N + 3 + HOLD_CYC cycles after the pulse starts.
- R7: A one-cycle `sw_rst` makes `core_en` 0 and `irq_stat` zero on the next cycle. `core_en` returns HOLD_CYC cycles after that, and reset-done is set BOOT_CYC cycles later.
- R8: A cycle with `clr_wr` high clears every status bit that has a one in `clr_data` and leaves the other bits as they are. A source event in the same cycle wins over the clear of its bit.
- R9: `src_evt[i]` sets `irq_stat[i+1]`. The `irq_n` output is low in a cycle exactly when some status bit is set whose enable bit, sampled in the previous cycle, is 1. Bit 0 always counts as enabled.
- R10: Source events that arrive before the chip is ready are dropped. Whenever `core_en` is 0, `irq_stat` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| supply_ok | input | 1 | Supply-above-threshold indication, asynchronous |
| rst_pin_n | input | 1 | External active-low hardware reset pin, asynchronous |
| sw_rst | input | 1 | Software reset strobe, one cycle |
| src_evt | input | NSRC | Event pulses from the other interrupt sources |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | NSRC+1 | Write-one-to-clear data for the status register |
| irq_en | input | NSRC+1 | Interrupt enable register; bit 0 is ignored |
| core_en | output | 1 | Enable for the internal measurement core |
| irq_stat | output | NSRC+1 | Interrupt status; bit 0 is reset-done |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
On every cycle, the assertions check several invariants. The reset-done flag always holds the pin low. The pin always matches the status bits gated by the previous cycle's enables. The status is empty whenever the core is off. A software strobe or a sustained supply loss always leaves the core off with an empty status. The bench scenarios cover what the assertions cannot see: the exact hold and settle lengths after each kind of start, the boundary between an ignored and a qualified pin pulse, events dropped during start-up, and write-one-to-clear behaviour under random traffic, including a set and a clear in the same cycle.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_BOOT  = 2'd2,
    ST_READY = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pwrup_rst_qual.sv
// Synchronizes the external reset pin and asserts hold once the pin has
// been low for QUAL_CYC consecutive synchronized cycles.
module pwrup_rst_qual #(
  parameter int QUAL_CYC = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic hold
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic          s_meta, s_sync;
  logic [QW-1:0] low_cnt, low_cnt_nxt;

  always_comb begin
    if (s_sync)                           low_cnt_nxt = '0;
    else if (low_cnt == QW'(QUAL_CYC))    low_cnt_nxt = low_cnt;
    else                                  low_cnt_nxt = low_cnt + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta  <= 1'b1;
      s_sync  <= 1'b1;
      low_cnt <= '0;
    end else begin
      s_meta  <= pin_n;
      s_sync  <= s_meta;
      low_cnt <= low_cnt_nxt;
    end
  end

  assign hold = (low_cnt == QW'(QUAL_CYC));
endmodule

// File: rtl/pwrup_fsm.sv
// Start-up state machine: off, hold delay, core settling, ready.
module pwrup_fsm
  import pwrup_pkg::*;
#(
  parameter int HOLD_CYC = 93080,
  parameter int BOOT_CYC = 143200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic restart,
  output logic core_en,
  output logic ready,
  output logic done,
  output logic wipe
);
  localparam int MAXC = (HOLD_CYC > BOOT_CYC) ? HOLD_CYC : BOOT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          sup_meta, sup_sync;
  seq_st_e       st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          hold_end, boot_end;

  assign hold_end = (cnt == CW'(HOLD_CYC - 1));
  assign boot_end = (cnt == CW'(BOOT_CYC - 1));
  assign wipe     = !sup_sync || restart;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (!sup_sync) begin
      st_nxt  = ST_OFF;
      cnt_nxt = '0;
    end else if (restart) begin
      st_nxt  = ST_HOLD;
      cnt_nxt = '0;
    end else begin
      case (st)
        ST_OFF: begin
          st_nxt  = ST_HOLD;
          cnt_nxt = '0;
        end
        ST_HOLD: begin
          if (hold_end) begin
            st_nxt  = ST_BOOT;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + CW'(1);
          end
        end
        ST_BOOT: begin
          if (boot_end) begin
            st_nxt  = ST_READY;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + CW'(1);
          end
        end
        default: begin
          st_nxt  = ST_READY;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_meta <= 1'b0;
      sup_sync <= 1'b0;
      st       <= ST_OFF;
      cnt      <= '0;
    end else begin
      sup_meta <= supply_ok;
      sup_sync <= sup_meta;
      st       <= st_nxt;
      cnt      <= cnt_nxt;
    end
  end

  assign core_en = (st == ST_BOOT) || (st == ST_READY);
  assign ready   = (st == ST_READY);
  assign done    = (st == ST_BOOT) && boot_end && !wipe;
endmodule

// File: rtl/pwrup_irq.sv
// Interrupt status register (write-one-to-clear) and registered pin.
module pwrup_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic            done,
  input  logic            ready,
  input  logic [NSRC-1:0] src_evt,
  input  logic            clr_wr,
  input  logic [NSRC:0]   clr_data,
  input  logic [NSRC:0]   irq_en,
  output logic [NSRC:0]   stat,
  output logic            irq_n
);
  logic [NSRC:0] stat_nxt, set_vec, clr_vec, en_eff;

  assign set_vec = {src_evt & {NSRC{ready}}, done};
  assign clr_vec = clr_wr ? clr_data : '0;
  assign en_eff  = irq_en | {{NSRC{1'b0}}, 1'b1};

  always_comb begin
    if (wipe) stat_nxt = '0;
    else      stat_nxt = (stat & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      irq_n <= 1'b1;
    end else begin
      stat  <= stat_nxt;
      irq_n <= ~|(stat_nxt & en_eff);
    end
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int HOLD_CYC = 93080,
  parameter int BOOT_CYC = 143200,
  parameter int QUAL_CYC = 36,
  parameter int NSRC     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            rst_pin_n,
  input  logic            sw_rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic            clr_wr,
  input  logic [NSRC:0]   clr_data,
  input  logic [NSRC:0]   irq_en,
  output logic            core_en,
  output logic [NSRC:0]   irq_stat,
  output logic            irq_n
);
  logic pin_hold, restart, ready, done, wipe;

  assign restart = pin_hold || sw_rst;

  pwrup_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (rst_pin_n),
    .hold  (pin_hold)
  );

  pwrup_fsm #(.HOLD_CYC(HOLD_CYC), .BOOT_CYC(BOOT_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .restart   (restart),
    .core_en   (core_en),
    .ready     (ready),
    .done      (done),
    .wipe      (wipe)
  );

  pwrup_irq #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (wipe),
    .done     (done),
    .ready    (ready),
    .src_evt  (src_evt),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .irq_en   (irq_en),
    .stat     (irq_stat),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
  parameter int NSRC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          sw_rst,
  input logic [NSRC:0] irq_en,
  input logic          core_en,
  input logic [NSRC:0] irq_stat,
  input logic          irq_n
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_supply_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !$past(supply_ok, 1) && !$past(supply_ok, 2) && !$past(supply_ok, 3))
      |-> (!core_en && irq_stat == '0 && irq_n));

  assert_done_needs_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat[0]) |-> core_en);

  assert_done_unmaskable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[0] |-> !irq_n);

  assert_sw_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && $past(sw_rst)) |-> (!core_en && irq_stat == '0));

  assert_pin_gating_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |->
      (irq_n == !(|(irq_stat & ($past(irq_en) | {{NSRC{1'b0}}, 1'b1})))));

  assert_empty_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (irq_stat == '0));
endmodule

bind pwrup_seq pwrup_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .sw_rst    (sw_rst),
  .irq_en    (irq_en),
  .core_en   (core_en),
  .irq_stat  (irq_stat),
  .irq_n     (irq_n)
);

// File: tb/sim_pwrup_seq.sv
`timescale 1ns/1ps
module sim_pwrup_seq;
  localparam int H = 20;
  localparam int B = 30;
  localparam int Q = 8;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n, supply_ok, rst_pin_n, sw_rst, clr_wr;
  logic [NS-1:0] src_evt;
  logic [NS:0]   clr_data, irq_en;
  logic          core_en, irq_n;
  logic [NS:0]   irq_stat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwrup_seq #(.HOLD_CYC(H), .BOOT_CYC(B), .QUAL_CYC(Q), .NSRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
    .sw_rst(sw_rst), .src_evt(src_evt), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq_en(irq_en), .core_en(core_en), .irq_stat(irq_stat), .irq_n(irq_n)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(inout int n);
    @(negedge clk);
    n++;
  endtask

  task automatic wait_core(input logic lvl, inout int n);
    int g = 0;
    while (core_en !== lvl && g < 5000) begin
      step(n);
      g++;
    end
  endtask

  task automatic wait_irq(inout int n);
    int g = 0;
    while (irq_n !== 1'b0 && g < 5000) begin
      step(n);
      g++;
    end
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = '1;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  function automatic logic [NS:0] model_stat(logic [NS:0] s, logic [NS-1:0] ev,
                                             logic cw, logic [NS:0] cd);
    return (s & ~(cw ? cd : '0)) | {ev, 1'b0};
  endfunction

  function automatic logic model_pin(logic [NS:0] s, logic [NS:0] en);
    return ~|(s & (en | 1));
  endfunction

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [NS:0] sm;
    logic [NS-1:0] ev;
    logic cw;
    logic [NS:0] cd, en;
    logic ok;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; supply_ok = 1'b0; rst_pin_n = 1'b1; sw_rst = 1'b0;
    src_evt = '0; clr_wr = 1'b0; clr_data = '0; irq_en = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset core_en", core_en, 0);
    chk("R1 reset irq_n", irq_n, 1);
    chk("R1 reset stat", irq_stat, 0);

    // power-up with all enables clear
    n = 0;
    supply_ok = 1'b1;
    wait_core(1'b1, n);
    chk("R2 hold length", n, 3 + H);
    n = 0;
    wait_irq(n);
    chk("R3 settle length", n, B);
    chk("R3 done flag", irq_stat, 1);
    repeat (3) @(negedge clk);
    chk("R4 flag unmaskable with irq_en=0", irq_n, 0);

    clear_all();
    chk("R8 w1c clears flag", irq_stat, 0);
    chk("R8 pin released", irq_n, 1);

    // set wins over clear in the same cycle
    src_evt = 3'b001; clr_wr = 1'b1; clr_data = 4'b0010;
    @(negedge clk);
    src_evt = '0; clr_wr = 1'b0; clr_data = '0;
    chk("R8 set beats clear", irq_stat, 4'b0010);
    chk("R9 disabled source keeps pin high", irq_n, 1);
    irq_en = 4'b0010;
    @(negedge clk);
    chk("R9 enabled source drives pin", irq_n, 0);
    clear_all();
    irq_en = '0;

    // random traffic against the model
    sm = '0;
    for (int i = 0; i < 400; i++) begin
      ev = NS'($urandom_range(0, 7));
      if ($urandom_range(0, 2) != 0) ev = '0;
      cw = ($urandom_range(0, 2) == 0);
      cd = (NS+1)'($urandom_range(0, 15));
      en = (NS+1)'($urandom_range(0, 15));
      src_evt = ev; clr_wr = cw; clr_data = cd; irq_en = en;
      @(negedge clk);
      sm = model_stat(sm, ev, cw, cd);
      chk("R8 random status", irq_stat, sm);
      chk("R9 random pin", irq_n, model_pin(sm, en));
    end
    src_evt = '0; clr_wr = 1'b0; clr_data = '0; irq_en = '0;
    @(negedge clk);
    clear_all();

    // software reset, events during start-up are dropped
    irq_en = '1;
    n = 0;
    sw_rst = 1'b1;
    step(n);
    sw_rst = 1'b0;
    chk("R7 core off after strobe", core_en, 0);
    chk("R7 status wiped", irq_stat, 0);
    src_evt = '1;
    step(n);
    src_evt = '0;
    wait_core(1'b1, n);
    chk("R7 restart hold length", n, 1 + H);
    src_evt = '1;
    @(negedge clk);
    src_evt = '0;
    chk("R10 events in settling dropped", irq_stat, 0);
    n = 1;
    wait_irq(n);
    chk("R7 restart settle length", n, B);
    chk("R10 only done flag after start", irq_stat, 1);
    irq_en = '0;
    clear_all();

    // short pin glitch ignored
    rst_pin_n = 1'b0;
    repeat (Q - 1) @(negedge clk);
    rst_pin_n = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (core_en !== 1'b1 || irq_stat !== '0) ok = 1'b0;
    end
    chk("R5 short glitch ignored", ok, 1);

    // long pin reset, held for Q+20 cycles
    n = 0;
    rst_pin_n = 1'b0;
    for (int k = 1; k <= Q + 20; k++) begin
      step(n);
      if (k == Q + 2) chk("R5 not yet qualified", core_en, 1);
      if (k == Q + 3) chk("R5 qualified drop", core_en, 0);
    end
    rst_pin_n = 1'b1;
    chk("R6 core held while pin low", core_en, 0);
    wait_core(1'b1, n);
    chk("R6 return after release", n, Q + 20 + 3 + H);
    n = 0;
    wait_irq(n);
    chk("R3 settle after pin reset", n, B);

    // supply loss
    n = 0;
    supply_ok = 1'b0;
    step(n); step(n);
    chk("R1 still on before sync", core_en, 1);
    step(n);
    chk("R1 core off after loss", core_en, 0);
    chk("R1 status wiped on loss", irq_stat, 0);
    chk("R1 pin high on loss", irq_n, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule